// File: doc/BRIEF.md
# Flag-Producing Control-Bit ALU

This block is a 16-bit combinational arithmetic logic unit for two's-complement words. Each result comes from a fixed chain of steps rather than from a decoded opcode. First, each operand can be cleared to zero and then bit-inverted, and the two operands are handled independently. Next, a single core step either adds the two conditioned operands or takes their bitwise AND. Last, the core result can be bit-inverted. Setting the six control bits in different ways yields constants, pass-through, negation, increment, decrement, sum, difference, AND and OR.

Two status outputs come from the final word. One flags a zero result and the other flags a negative result. The block has no clock and no state, so a caller sees the result in the same cycle that it presents the operands. Because nothing is buffered, there is no valid/ready handshake and no back-pressure. A caller that needs a registered result places its own register after the block.

Top module: `flag_alu`

## Requirements
- R1: When `clr_a` is 1, operand A is replaced by 0x0000 before any other step. When it is 0, `opnd_a` passes on unchanged.
- R2: When `clr_b` is 1, operand B is replaced by 0x0000 in the same way, independently of `clr_a`.
- R3: `inv_a` and `inv_b` bit-invert their own operand after the clear step. A clear and an invert together give 0xFFFF.
- R4: With `fn_sum` = 1, the core result is the 16-bit two's-complement sum of the conditioned operands, and the carry out of bit 15 is dropped.
- R5: With `fn_sum` = 0, the core result is the bitwise AND of the conditioned operands.
- R6: With `inv_res` = 1, `res` is the bitwise inverse of the core result. Otherwise it equals the core result.
- R7: `is_zero` is 1 exactly when all 16 bits of `res` are 0.
- R8: `is_neg` equals bit 15 of `res`.
- R9: Writing the control word as {clr_a,inv_a,clr_b,inv_b,fn_sum,inv_res}, the codes give these results:
  - 101010 gives 0
  - 111111 gives 1
  - 111010 gives -1
  - 001100 gives A
  - 110000 gives B
  - 001101 gives ~A
  - 110001 gives ~B
  - 001111 gives -A
  - 110011 gives -B
  - 011111 gives A+1
  - 110111 gives B+1
  - 001110 gives A-1
  - 110010 gives B-1
  - 000010 gives A+B
  - 010011 gives A-B
  - 000111 gives B-A
  - 000000 gives A&B
  - 010101 gives A|B

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | Operand A, two's complement |
| opnd_b | input | 16 | Operand B, two's complement |
| clr_a | input | 1 | Clear operand A to zero |
| inv_a | input | 1 | Invert operand A after the clear step |
| clr_b | input | 1 | Clear operand B to zero |
| inv_b | input | 1 | Invert operand B after the clear step |
| fn_sum | input | 1 | Core step: 1 = add, 0 = AND |
| inv_res | input | 1 | Invert the core result |
| res | output | 16 | Final result |
| is_zero | output | 1 | 1 when res is zero |
| is_neg | output | 1 | Copy of res bit 15 |

## Verification
The bench runs all eighteen named control codes on the corner words 0x0000, 0xFFFF, 0x7FFF and 0x8000, and on seeded random words. Two kinds of fault show up on these inputs:
- A design that inverts before it clears returns 0x0000 where 0xFFFF is expected.
- A design that keeps a carry or sign-extends gives wrong results for sums such as 0x7FFF+1 and 0xFFFF+1.

The bench also sweeps all 64 control codes with random operands, so a swapped or misrouted control bit gives a mismatch. Flag checks on results equal to zero and on results with only bit 15 set would catch a zero flag built from part of the word, or a sign flag taken from the core result instead of the final result.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic {
    CORE_AND = 1'b0,
    CORE_SUM = 1'b1
  } core_sel_e;
endpackage

// File: rtl/alu_opnd_cond.sv
module alu_opnd_cond #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] din,
  input  logic         clr,
  input  logic         inv,
  output logic [W-1:0] dout
);
  always_comb begin
    logic [W-1:0] cleared;
    cleared = clr ? '0 : din;
    dout    = inv ? ~cleared : cleared;
    // R1 R2 R3
    if (clr) begin
      zero_force_chk: assert (dout == {W{inv}})
        else $error("clear step not applied before invert");
    end else begin
      pass_chk: assert ((dout ^ din) == {W{inv}})
        else $error("operand not passed or inverted");
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  core_sel_e    sel,
  output logic [W-1:0] y
);
  always_comb begin
    logic [W-1:0] sum_w;
    logic [W-1:0] and_w;
    sum_w = a + b;
    and_w = a & b;
    y     = (sel == CORE_SUM) ? sum_w : and_w;
    if (sel == CORE_SUM) begin
      // R4
      sum_wrap_chk: assert (W'(y - b) == a)
        else $error("sum does not wrap modulo word size");
    end else begin
      // R5
      and_mask_chk: assert (((y & ~a) == '0) && ((y & ~b) == '0))
        else $error("AND result has bits outside an operand");
    end
  end
endmodule

// File: rtl/alu_res_stage.sv
module alu_res_stage #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] core,
  input  logic         inv,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    res     = inv ? ~core : core;
    is_zero = ~(|res);
    is_neg  = res[MSB];
    // R7 R8
    flag_excl_chk: assert (!(is_zero && is_neg))
      else $error("zero and negative flags both set");
    // R6
    inv_res_chk: assert ((res ^ core) == {W{inv}})
      else $error("output inversion mismatch");
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
(
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic              clr_a,
  input  logic              inv_a,
  input  logic              clr_b,
  input  logic              inv_b,
  input  logic              fn_sum,
  input  logic              inv_res,
  output logic [WORD_W-1:0] res,
  output logic              is_zero,
  output logic              is_neg
);
  localparam int unsigned NOPND = 2;

  logic [WORD_W-1:0] raw  [NOPND];
  logic [WORD_W-1:0] cond [NOPND];
  logic [NOPND-1:0]  clr_v;
  logic [NOPND-1:0]  inv_v;
  logic [WORD_W-1:0] core_y;

  assign raw[0] = opnd_a;
  assign raw[1] = opnd_b;
  assign clr_v  = {clr_b, clr_a};
  assign inv_v  = {inv_b, inv_a};

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    alu_opnd_cond #(.W(WORD_W)) i_cond (
      .din  (raw[g]),
      .clr  (clr_v[g]),
      .inv  (inv_v[g]),
      .dout (cond[g])
    );
  end

  alu_core #(.W(WORD_W)) i_core (
    .a   (cond[0]),
    .b   (cond[1]),
    .sel (core_sel_e'(fn_sum)),
    .y   (core_y)
  );

  alu_res_stage #(.W(WORD_W)) i_res (
    .core    (core_y),
    .inv     (inv_res),
    .res     (res),
    .is_zero (is_zero),
    .is_neg  (is_neg)
  );
endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] a, b, res;
  logic [5:0]  ctl;
  logic        is_zero, is_neg;
  int          checks = 0;
  int          errors = 0;

  flag_alu i_flag_alu (
    .opnd_a(a), .opnd_b(b),
    .clr_a(ctl[5]), .inv_a(ctl[4]), .clr_b(ctl[3]), .inv_b(ctl[2]),
    .fn_sum(ctl[1]), .inv_res(ctl[0]),
    .res(res), .is_zero(is_zero), .is_neg(is_neg)
  );

  // Golden model from R1-style step rules, control {clr_a,inv_a,clr_b,inv_b,fn_sum,inv_res}
  function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] y,
                                         input logic [5:0] c);
    logic [15:0] p, q, r;
    p = c[5] ? 16'h0 : x;  p = c[4] ? ~p : p;
    q = c[3] ? 16'h0 : y;  q = c[2] ? ~q : q;
    r = c[1] ? 16'(p + q) : (p & q);
    return c[0] ? ~r : r;
  endfunction

  // Arithmetic meaning of the eighteen named codes (R9)
  function automatic logic [15:0] named_val(input int k, input logic [15:0] x,
                                             input logic [15:0] y);
    case (k)
      0: return 16'd0;      1: return 16'd1;      2: return 16'hFFFF;
      3: return x;          4: return y;          5: return ~x;
      6: return ~y;         7: return 16'(-x);    8: return 16'(-y);
      9: return 16'(x + 1); 10: return 16'(y + 1); 11: return 16'(x - 1);
      12: return 16'(y - 1); 13: return 16'(x + y); 14: return 16'(x - y);
      15: return 16'(y - x); 16: return x & y;    default: return x | y;
    endcase
  endfunction

  function automatic logic [5:0] named_code(input int k);
    case (k)
      0: return 6'b101010;  1: return 6'b111111;  2: return 6'b111010;
      3: return 6'b001100;  4: return 6'b110000;  5: return 6'b001101;
      6: return 6'b110001;  7: return 6'b001111;  8: return 6'b110011;
      9: return 6'b011111;  10: return 6'b110111; 11: return 6'b001110;
      12: return 6'b110010; 13: return 6'b000010; 14: return 6'b010011;
      15: return 6'b000111; 16: return 6'b000000; default: return 6'b010101;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h ctl=%b actual=%h expected=%h", req, a, b, ctl, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [5:0] c);
    @(negedge clk);
    a = x; b = y; ctl = c;
    @(posedge clk);
    #1;
  endtask

  task automatic full_chk(input string req, input logic [15:0] exp);
    chk(req, res, exp);
    chk("R7", {15'd0, is_zero}, {15'd0, exp == 16'h0});
    chk("R8", {15'd0, is_neg}, {15'd0, exp[15]});
  endtask

  logic [15:0] corner [4];

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    corner[0] = 16'h0000; corner[1] = 16'hFFFF;
    corner[2] = 16'h7FFF; corner[3] = 16'h8000;
    a = '0; b = '0; ctl = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // initial state: zero inputs, AND of zeros
    full_chk("R5", 16'h0000);

    // R1 R3: clear then invert on A gives all ones; R2 independent clear of B
    apply(16'h1234, 16'h5678, 6'b110000);
    chk("R3", res, 16'h5678 & 16'hFFFF);
    apply(16'h1234, 16'h5678, 6'b100010);
    chk("R1", res, 16'h5678);
    apply(16'h1234, 16'h5678, 6'b001010);
    chk("R2", res, 16'h1234);
    apply(16'hAAAA, 16'h5555, 6'b111110);
    chk("R3", res, 16'hFFFE);
    // R4: wrap-around of the carry
    apply(16'hFFFF, 16'h0001, 6'b000010);
    full_chk("R4", 16'h0000);
    apply(16'h7FFF, 16'h0001, 6'b000010);
    full_chk("R4", 16'h8000);
    // R5 and R6
    apply(16'hF0F0, 16'h3C3C, 6'b000000);
    chk("R5", res, 16'h3030);
    apply(16'hF0F0, 16'h3C3C, 6'b000001);
    chk("R6", res, 16'hCFCF);

    // R9: named codes on corners and random words
    for (int k = 0; k < 18; k++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          apply(corner[i], corner[j], named_code(k));
          full_chk("R9", named_val(k, corner[i], corner[j]));
        end
      end
      for (int n = 0; n < 20; n++) begin
        logic [15:0] rx, ry;
        rx = 16'($urandom); ry = 16'($urandom);
        apply(rx, ry, named_code(k));
        full_chk("R9", named_val(k, rx, ry));
      end
    end

    // R1..R6 sweep of every control code against the step model
    for (int c = 0; c < 64; c++) begin
      for (int n = 0; n < 8; n++) begin
        logic [15:0] rx, ry;
        rx = (n < 4) ? corner[n] : 16'($urandom);
        ry = 16'($urandom);
        apply(rx, ry, 6'(c));
        full_chk("R6", model(rx, ry, 6'(c)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule